// File: doc/BRIEF.md
# Stack Limit Violation Checker

This block sits beside the address path of a 16-bit minicomputer core and judges every access the core makes through its stack pointer while in kernel mode. Each such access lands in one of three classes: legal, yellow (the stack is getting close to its floor) or red (the stack has gone past its floor, or it targets the processor status word location at the top of the address space). Accesses that do not go through the stack pointer, or that are made outside kernel mode, are never judged.

A yellow access completes normally. The block remembers it and raises a one-cycle trap request when the core signals the end of the current instruction. A red access is aborted in the same cycle, so a faulting write never reaches memory. The block then runs a fixed four-step emergency sequence. It writes the old PC to physical address 0 and the old PSW to physical address 2, reloads the stack pointer with 4, and fetches through the error trap vector at address 4. The core's microsequencer carries out these steps; this block only drives the request and control outputs. A software-loadable limit register supplies the upper byte of the stack floor. Its low byte always reads as all ones.

Top module: `stack_guard`

## Requirements
- R1: After reset the limit register holds 0, so `lim_rdata` reads 16'h00FF. Also after reset `seq_busy_o`, `yel_trap_o`, `abort_o` are 0 and `cls_o` is 2'b00 (legal).
- R2: With the limit register holding L, a checked access is classed red (`cls_o`=2'b10) when its address is below L*256+224. It is classed yellow (2'b01) from L*256+224 up to L*256+255. It is classed legal (2'b00) above L*256+255. With L=0 this makes octal 336 red, octal 340 to 376 yellow and octal 400 legal.
- R3: A checked access at address 16'hFFFE or above is red, whatever value the limit register holds, including L=8'hFF where the range rule alone would give yellow.
- R4: An access is checked only when `acc_valid`, `acc_stack` and `acc_kernel` are all 1 and no emergency sequence is running. Any other access gives `cls_o`=2'b00 and no abort.
- R5: A red access drives `abort_o` in the same cycle, and also drives `wr_inhibit_o` when `acc_write` is 1. A red access is never also reported as yellow.
- R6: In the four cycles after a red access, the block drives the emergency sequence in this order, one step per cycle, with `seq_busy_o`=1 throughout:
  - a save write to address 0 with the PC selected (`save_sel_psw_o`=0);
  - a save write to address 2 with the PSW selected (`save_sel_psw_o`=1);
  - `sp_load_o` with `sp_value_o`=4;
  - `vec_fetch_o` with `vec_addr_o`=4.
- R7: A yellow access never aborts. It raises `yel_trap_o` for one cycle, in the first cycle at or after the access in which `instr_end` is 1 and no sequence runs.
- R8: A red access discards any yellow trap still pending, so no yellow trap follows the emergency sequence.
- R9: An access presented while the emergency sequence runs is not classified and neither restarts nor lengthens the sequence.
- R10: A write with `lim_we`=1 loads `lim_wdata` into the limit register at the next clock edge. `lim_rdata` then reads {limit, 8'hFF}, and later classification uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lim_we | input | 1 | Load the limit register |
| lim_wdata | input | 8 | New limit (upper byte of the stack floor) |
| lim_rdata | output | 16 | Limit register as read by software |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 16 | Access address |
| acc_stack | input | 1 | Access is addressed through the stack pointer |
| acc_kernel | input | 1 | Access is made in kernel mode |
| acc_write | input | 1 | Access is a write |
| instr_end | input | 1 | Current instruction completes this cycle |
| cls_o | output | 2 | Class: 00 legal, 01 yellow, 10 red |
| abort_o | output | 1 | Abort the current access (red) |
| wr_inhibit_o | output | 1 | Suppress the current memory write |
| yel_trap_o | output | 1 | Yellow-zone trap request |
| seq_busy_o | output | 1 | Emergency sequence in progress |
| save_wr_o | output | 1 | Emergency save write strobe |
| save_addr_o | output | 16 | Emergency save address |
| save_sel_psw_o | output | 1 | Save data select: 0 PC, 1 PSW |
| sp_load_o | output | 1 | Reload the stack pointer |
| sp_value_o | output | 16 | Value for the stack pointer reload |
| vec_fetch_o | output | 1 | Fetch through the error trap vector |
| vec_addr_o | output | 16 | Error trap vector address |

## Verification
The assertions assume the following about the inputs:
- The core holds its access inputs stable for a whole cycle.
- The core presents no access while its own emergency steps run, except for the deliberate intrusions that the bench uses to show such accesses are ignored.
- `acc_addr` is only meaningful while `acc_valid` is high.

The stimulus is driven at the falling edge and follows these assumptions. It places addresses exactly at each zone edge for several limit values, including the extremes 0 and 8'hFF. It aligns yellow accesses both with and ahead of `instr_end`, and it injects an access during a running sequence only to check that the access is ignored.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
   typedef enum logic [1:0] {
      ZONE_OK  = 2'b00,
      ZONE_YEL = 2'b01,
      ZONE_RED = 2'b10
   } zone_e;

   typedef enum logic [2:0] {
      SQ_IDLE     = 3'd0,
      SQ_SAVE_PC  = 3'd1,
      SQ_SAVE_PSW = 3'd2,
      SQ_LOAD_SP  = 3'd3,
      SQ_VECTOR   = 3'd4
   } seq_e;
endpackage

// File: rtl/stack_guard_limit.sv
module stack_guard_limit #(
   parameter int unsigned AW      = 16,
   parameter int unsigned LIMW    = 8,
   parameter int unsigned LIM_RST = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [LIMW-1:0] wdata,
   output logic [LIMW-1:0] limit_o,
   output logic [AW-1:0]   rdata_o
);
   localparam int unsigned LOW = AW - LIMW;

   if (LIMW == 0 || LIMW >= AW) begin : g_bad_width
      $error("stack_guard_limit: LIMW must lie in 1..AW-1");
   end
   if (LIM_RST >= (1 << LIMW)) begin : g_bad_reset
      $error("stack_guard_limit: LIM_RST does not fit in LIMW bits");
   end

   logic [LIMW-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lim_q <= LIMW'(LIM_RST);
      else if (we) lim_q <= wdata;
   end

   assign limit_o = lim_q;
   assign rdata_o = {lim_q, {LOW{1'b1}}};
endmodule

// File: rtl/stack_guard_zone.sv
module stack_guard_zone
   import stack_guard_pkg::*;
#(
   parameter int unsigned AW         = 16,
   parameter int unsigned LIMW       = 8,
   parameter int unsigned YEL_BYTES  = 32,
   parameter int unsigned GUARD_ADDR = 16'hFFFE
) (
   input  logic            chk_en,
   input  logic [AW-1:0]   addr,
   input  logic [LIMW-1:0] limit,
   output zone_e           zone_o
);
   localparam int unsigned LOW = AW - LIMW;

   if (YEL_BYTES >= (1 << LOW)) begin : g_bad_yel
      $error("stack_guard_zone: YEL_BYTES must be below one limit step");
   end
   if (GUARD_ADDR >= (1 << AW)) begin : g_bad_guard
      $error("stack_guard_zone: GUARD_ADDR out of address range");
   end

   localparam logic [AW-1:0] GUARD   = AW'(GUARD_ADDR);
   localparam logic [AW-1:0] YEL_OFS = AW'((1 << LOW) - YEL_BYTES);

   logic [AW-1:0] hi_addr;
   logic          in_guard;
   logic          below_floor;
   logic          in_yel;

   assign hi_addr  = {limit, {LOW{1'b1}}};
   assign in_guard = (addr >= GUARD);

   if (YEL_BYTES > 0) begin : g_two_zone
      logic [AW-1:0] lo_addr;
      assign lo_addr     = {limit, {LOW{1'b0}}} + YEL_OFS;
      assign below_floor = (addr < lo_addr);
      assign in_yel      = !below_floor && (addr <= hi_addr);
   end else begin : g_red_only
      assign below_floor = (addr <= hi_addr);
      assign in_yel      = 1'b0;
   end

   always_comb begin
      zone_o = ZONE_OK;
      if (chk_en) begin
         if (in_guard || below_floor) zone_o = ZONE_RED;
         else if (in_yel)             zone_o = ZONE_YEL;
      end
   end
endmodule

// File: rtl/stack_guard_seq.sv
module stack_guard_seq
   import stack_guard_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned PC_SLOT   = 0,
   parameter int unsigned PSW_SLOT  = 2,
   parameter int unsigned SP_RELOAD = 4,
   parameter int unsigned TRAP_VEC  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy_o,
   output logic          save_wr_o,
   output logic          save_sel_psw_o,
   output logic [AW-1:0] save_addr_o,
   output logic          sp_load_o,
   output logic [AW-1:0] sp_value_o,
   output logic          vec_fetch_o,
   output logic [AW-1:0] vec_addr_o
);
   if (PC_SLOT == PSW_SLOT) begin : g_bad_slots
      $error("stack_guard_seq: PC and PSW save slots must differ");
   end

   seq_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE:     if (start) st_d = SQ_SAVE_PC;
         SQ_SAVE_PC:  st_d = SQ_SAVE_PSW;
         SQ_SAVE_PSW: st_d = SQ_LOAD_SP;
         SQ_LOAD_SP:  st_d = SQ_VECTOR;
         SQ_VECTOR:   st_d = SQ_IDLE;
         default:     st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end

   assign busy_o         = (st_q != SQ_IDLE);
   assign save_wr_o      = (st_q == SQ_SAVE_PC) || (st_q == SQ_SAVE_PSW);
   assign save_sel_psw_o = (st_q == SQ_SAVE_PSW);
   assign save_addr_o    = (st_q == SQ_SAVE_PSW) ? AW'(PSW_SLOT) : AW'(PC_SLOT);
   assign sp_load_o      = (st_q == SQ_LOAD_SP);
   assign sp_value_o     = AW'(SP_RELOAD);
   assign vec_fetch_o    = (st_q == SQ_VECTOR);
   assign vec_addr_o     = AW'(TRAP_VEC);
endmodule

// File: rtl/stack_guard_yel.sv
module stack_guard_yel (
   input  logic clk,
   input  logic rst_n,
   input  logic yel_hit,
   input  logic red_hit,
   input  logic instr_end,
   input  logic busy,
   output logic trap_o
);
   logic pend_q;
   logic fire;

   assign fire   = instr_end && !busy;
   assign trap_o = fire && (pend_q || yel_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (red_hit) pend_q <= 1'b0;
      else if (fire)    pend_q <= 1'b0;
      else if (yel_hit) pend_q <= 1'b1;
   end
endmodule

// File: rtl/stack_guard.sv
module stack_guard
   import stack_guard_pkg::*;
#(
   parameter int unsigned AW         = 16,
   parameter int unsigned LIMW       = 8,
   parameter int unsigned LIM_RST    = 0,
   parameter int unsigned YEL_BYTES  = 32,
   parameter int unsigned GUARD_ADDR = 16'hFFFE,
   parameter int unsigned PC_SLOT    = 0,
   parameter int unsigned PSW_SLOT   = 2,
   parameter int unsigned SP_RELOAD  = 4,
   parameter int unsigned TRAP_VEC   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lim_we,
   input  logic [LIMW-1:0] lim_wdata,
   output logic [AW-1:0]   lim_rdata,
   input  logic            acc_valid,
   input  logic [AW-1:0]   acc_addr,
   input  logic            acc_stack,
   input  logic            acc_kernel,
   input  logic            acc_write,
   input  logic            instr_end,
   output logic [1:0]      cls_o,
   output logic            abort_o,
   output logic            wr_inhibit_o,
   output logic            yel_trap_o,
   output logic            seq_busy_o,
   output logic            save_wr_o,
   output logic [AW-1:0]   save_addr_o,
   output logic            save_sel_psw_o,
   output logic            sp_load_o,
   output logic [AW-1:0]   sp_value_o,
   output logic            vec_fetch_o,
   output logic [AW-1:0]   vec_addr_o
);
   logic [LIMW-1:0] limit;
   logic            chk_en;
   zone_e           zone;
   logic            red_hit;
   logic            yel_hit;

   stack_guard_limit #(.AW(AW), .LIMW(LIMW), .LIM_RST(LIM_RST)) i_limit (
      .clk(clk), .rst_n(rst_n), .we(lim_we), .wdata(lim_wdata),
      .limit_o(limit), .rdata_o(lim_rdata)
   );

   assign chk_en = acc_valid && acc_stack && acc_kernel && !seq_busy_o;

   stack_guard_zone #(
      .AW(AW), .LIMW(LIMW), .YEL_BYTES(YEL_BYTES), .GUARD_ADDR(GUARD_ADDR)
   ) i_zone (
      .chk_en(chk_en), .addr(acc_addr), .limit(limit), .zone_o(zone)
   );

   assign red_hit      = (zone == ZONE_RED);
   assign yel_hit      = (zone == ZONE_YEL);
   assign cls_o        = zone;
   assign abort_o      = red_hit;
   assign wr_inhibit_o = red_hit && acc_write;

   stack_guard_seq #(
      .AW(AW), .PC_SLOT(PC_SLOT), .PSW_SLOT(PSW_SLOT),
      .SP_RELOAD(SP_RELOAD), .TRAP_VEC(TRAP_VEC)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .start(red_hit), .busy_o(seq_busy_o),
      .save_wr_o(save_wr_o), .save_sel_psw_o(save_sel_psw_o),
      .save_addr_o(save_addr_o), .sp_load_o(sp_load_o),
      .sp_value_o(sp_value_o), .vec_fetch_o(vec_fetch_o),
      .vec_addr_o(vec_addr_o)
   );

   stack_guard_yel i_yel (
      .clk(clk), .rst_n(rst_n), .yel_hit(yel_hit), .red_hit(red_hit),
      .instr_end(instr_end), .busy(seq_busy_o), .trap_o(yel_trap_o)
   );
endmodule

// File: rtl/stack_guard_chk.sv
module stack_guard_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic [15:0] acc_addr,
   input logic        acc_stack,
   input logic        acc_kernel,
   input logic        acc_write,
   input logic        instr_end,
   input logic [15:0] lim_rdata,
   input logic [1:0]  cls_o,
   input logic        abort_o,
   input logic        wr_inhibit_o,
   input logic        yel_trap_o,
   input logic        seq_busy_o,
   input logic        save_wr_o,
   input logic [15:0] save_addr_o,
   input logic        save_sel_psw_o,
   input logic        sp_load_o,
   input logic [15:0] sp_value_o,
   input logic        vec_fetch_o,
   input logic [15:0] vec_addr_o
);
   // R10: low byte of the readback is always all ones
   p_lim_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lim_rdata[7:0] == 8'hFF);

   // R3: status-word region is red whatever the limit
   p_guard_red_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_stack && acc_kernel && !seq_busy_o && acc_addr >= 16'hFFFE)
      |-> cls_o == 2'b10);

   // R4: unchecked accesses never classify
   p_unchecked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid || !acc_stack || !acc_kernel) |-> (cls_o == 2'b00 && !abort_o));

   p_red_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (cls_o == 2'b10 && wr_inhibit_o == acc_write));

   p_red_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> (save_wr_o && !save_sel_psw_o && save_addr_o == 16'd0 && seq_busy_o));

   p_pc_then_psw_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (save_wr_o && !save_sel_psw_o) |=> (save_wr_o && save_sel_psw_o && save_addr_o == 16'd2));

   p_psw_then_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (save_wr_o && save_sel_psw_o) |=> (sp_load_o && sp_value_o == 16'd4));

   p_sp_then_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_load_o |=> (vec_fetch_o && vec_addr_o == 16'd4));

   p_steps_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({save_wr_o, sp_load_o, vec_fetch_o}));

   p_trap_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      yel_trap_o |-> (instr_end && !seq_busy_o && !abort_o));

   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy_o |-> (cls_o == 2'b00 && !abort_o));
endmodule

bind stack_guard stack_guard_chk i_stack_guard_chk (.*);

// File: tb/test_stack_guard.sv
module test_stack_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lim_we = 1'b0;
   logic [7:0]  lim_wdata = 8'h00;
   logic [15:0] lim_rdata;
   logic        acc_valid = 1'b0;
   logic [15:0] acc_addr = 16'h0000;
   logic        acc_stack = 1'b0;
   logic        acc_kernel = 1'b0;
   logic        acc_write = 1'b0;
   logic        instr_end = 1'b0;
   logic [1:0]  cls_o;
   logic        abort_o, wr_inhibit_o, yel_trap_o, seq_busy_o;
   logic        save_wr_o, save_sel_psw_o, sp_load_o, vec_fetch_o;
   logic [15:0] save_addr_o, sp_value_o, vec_addr_o;

   always #10 clk = ~clk;

   stack_guard i_stack_guard (.*);

   typedef struct packed {
      logic [1:0]  cls;
      logic        abort;
      logic        wrinh;
      logic        trap;
      logic        busy;
      logic        swr;
      logic        spsw;
      logic [15:0] saddr;
      logic        spl;
      logic [15:0] spv;
      logic        vecf;
      logic [15:0] veca;
      logic [15:0] lim;
   } obs_t;

   obs_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   // bench model state, from the requirements
   logic [7:0] m_lim = 8'h00;
   bit         m_pend = 1'b0;
   int         m_ph = 0;

   function automatic logic [1:0] zone_of(logic [15:0] a, logic [7:0] l);
      int base;
      base = int'(l) * 256;
      if (a >= 16'hFFFE)          return 2'b10;
      if (int'(a) > base + 255)   return 2'b00;
      if (int'(a) >= base + 224)  return 2'b01;
      return 2'b10;
   endfunction

   task automatic step(input bit v, input logic [15:0] a, input bit stk, input bit krn,
                       input bit wr, input bit ie, input bit lwe, input logic [7:0] lwd,
                       input string tag);
      obs_t e;
      bit busy, chk;
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_stack = stk; acc_kernel = krn;
      acc_write = wr; instr_end = ie; lim_we = lwe; lim_wdata = lwd;
      busy = (m_ph != 0);
      chk = v && stk && krn && !busy;
      e = '0;
      e.cls   = chk ? zone_of(a, m_lim) : 2'b00;
      e.abort = (e.cls == 2'b10);
      e.wrinh = e.abort && wr;
      e.trap  = ie && !busy && (m_pend || e.cls == 2'b01);
      e.busy  = busy;
      e.swr   = (m_ph == 1) || (m_ph == 2);
      e.spsw  = (m_ph == 2);
      e.saddr = (m_ph == 2) ? 16'd2 : 16'd0;
      e.spl   = (m_ph == 3);
      e.spv   = 16'd4;
      e.vecf  = (m_ph == 4);
      e.veca  = 16'd4;
      e.lim   = {m_lim, 8'hFF};
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (e.abort)                  m_pend = 1'b0;
      else if (ie && !busy)         m_pend = 1'b0;
      else if (e.cls == 2'b01)      m_pend = 1'b1;
      if (m_ph == 0) m_ph = e.abort ? 1 : 0;
      else           m_ph = (m_ph == 4) ? 0 : m_ph + 1;
      if (lwe) m_lim = lwd;
   endtask

   task automatic acc(input logic [15:0] a, input bit wr, input bit ie, input string tag);
      step(1'b1, a, 1'b1, 1'b1, wr, ie, 1'b0, 8'h00, tag);
   endtask

   task automatic idle(input int n, input bit ie, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, ie, 1'b0, 8'h00, tag);
   endtask

   task automatic set_lim(input logic [7:0] l, input string tag);
      step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, l, tag);
   endtask

   // monitor: compare each cycle's outputs against the queued expectation
   initial begin
      obs_t a, e;
      string t;
      forever begin
         @(negedge clk);
         #5;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{cls_o, abort_o, wr_inhibit_o, yel_trap_o, seq_busy_o, save_wr_o,
                  save_sel_psw_o, save_addr_o, sp_load_o, sp_value_o, vec_fetch_o,
                  vec_addr_o, lim_rdata};
            checks++;
            if (a !== e) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", t, a, e);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2, 1'b0, "R1 reset state");

      // R2 zone edges with reset limit
      acc(16'o000400, 1'b0, 1'b0, "R2 octal 400 legal");
      acc(16'o001000, 1'b1, 1'b0, "R2 octal 1000 legal");
      acc(16'o000376, 1'b0, 1'b0, "R2 octal 376 yellow");
      idle(1, 1'b1, "R7 yellow trap at instr end");
      idle(1, 1'b1, "R7 trap only once");
      acc(16'o000340, 1'b1, 1'b1, "R7 yellow trap same cycle, no abort");
      acc(16'o000336, 1'b1, 1'b0, "R2 R5 octal 336 red, write inhibited");
      idle(4, 1'b0, "R6 emergency sequence");
      idle(1, 1'b0, "R6 sequence ended");

      // R4 unchecked accesses
      step(1'b1, 16'o000336, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R4 non-stack access");
      step(1'b1, 16'o000336, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R4 non-kernel access");
      step(1'b0, 16'o000336, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R4 no valid");

      // R8 red discards pending yellow
      acc(16'o000350, 1'b0, 1'b0, "R8 yellow pending");
      acc(16'o000100, 1'b0, 1'b0, "R8 red read, no inhibit");
      idle(2, 1'b1, "R8 instr end during sequence");
      acc(16'o000010, 1'b1, 1'b0, "R9 red during sequence ignored");
      idle(1, 1'b0, "R9 sequence not restarted");
      idle(2, 1'b1, "R8 no trap after sequence");

      // R10 limit load and R2 with a new limit
      set_lim(8'h12, "R10 write cycle shows old limit");
      idle(1, 1'b0, "R10 new limit readback");
      acc(16'h1300, 1'b0, 1'b0, "R2 above new floor legal");
      acc(16'h12FE, 1'b0, 1'b1, "R2 top of new yellow");
      acc(16'h12E0, 1'b0, 1'b1, "R2 bottom of new yellow");
      acc(16'h12DE, 1'b1, 1'b0, "R2 below new yellow red");
      idle(5, 1'b0, "R6 sequence with new limit");
      acc(16'o000336, 1'b0, 1'b0, "R10 old red address now red too");
      idle(5, 1'b0, "R6 sequence again");

      // R3 guard region
      set_lim(8'hFF, "R3 limit to max");
      acc(16'hFFFC, 1'b0, 1'b1, "R3 FFFC yellow under max limit");
      acc(16'hFFFE, 1'b1, 1'b0, "R3 FFFE red under max limit");
      idle(5, 1'b0, "R3 sequence");
      set_lim(8'h00, "R3 limit to zero");
      acc(16'hFFFE, 1'b1, 1'b0, "R3 FFFE red under zero limit");
      idle(5, 1'b0, "R3 sequence");
      acc(16'hFFFC, 1'b0, 1'b0, "R3 FFFC legal under zero limit");

      idle(2, 1'b0, "drain");
      @(negedge clk);
      #8;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule